// File: doc/BRIEF.md
# Nibble-Serial Sample Link

This block carries 16-bit converter samples across a narrow four-line data path. On the transmit side it takes one parallel word, together with a 4-bit side word, and sends it as four nibbles in four consecutive master-clock cycles. A word-start strobe marks the first of these cycles. A single side line carries one side bit in each cycle, next to the data nibble. On the receive side it rebuilds the 16-bit word and the side word from the lines. It checks that the strobe recurs exactly every four cycles, and after a framing fault it realigns to the strobe.

The transmitter offers a load slot once per word. If no word is offered in that slot, it sends an all-zero word and flags an underrun for that word's duration. The receiver stays idle until it sees its first strobe. It pulses a valid output once for each complete word.

Top module: `nibble_link`

## Requirements
- R1: In transmit slot k (k = 0..3, slot 0 being the strobe cycle), data line i carries bit 4k+i of the loaded word.
- R2: `tx_strobe_o` is high in slot 0 only, so it repeats every 4 cycles, and it is low while in reset.
- R3: In transmit slot k, `tx_aux_o` carries bit k of the loaded side word.
- R4: `tx_ready_o` is high in the last slot, which is also the first cycle after reset. A word with `tx_valid_i` high in that cycle is sent starting with the next cycle.
- R5: If `tx_valid_i` is low while `tx_ready_o` is high, the next word goes out as all-zero data and all-zero side bits, and `tx_underrun_o` stays high for its four slots. The flag clears for a valid word.
- R6: After the receiver samples the fourth nibble of a word framed by a strobe, `rx_valid_o` is high for exactly one cycle, starting one cycle after that sample. In the same cycle `rx_word_o` and `rx_aux_word_o` hold the word, with the nibble of slot k at bits 4k+3..4k and the side bit of slot k at bit k.
- R7: A strobe sampled while the receiver is locked and expects a slot other than 0 raises `rx_frame_err_o` for one cycle. The partial word is discarded, and the strobe cycle becomes slot 0 of a new word.
- R8: A missing strobe where slot 0 is expected raises `rx_frame_err_o` for one cycle and drops lock. No word is emitted until the next strobe starts a new word.
- R9: After reset and before the first strobe, the receiver emits neither valid nor a framing error, whatever is on the lines.
- R10: In reset, `tx_lane_o`, `tx_aux_o`, `tx_underrun_o`, `rx_valid_o` and `rx_frame_err_o` are 0, and `tx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | 16 | Parallel word to send |
| tx_aux_word_i | input | 4 | Side word to send |
| tx_valid_i | input | 1 | Word offered in the load slot |
| tx_ready_o | output | 1 | Load slot, word taken this cycle |
| tx_lane_o | output | 4 | Transmit data lines |
| tx_aux_o | output | 1 | Transmit side line |
| tx_strobe_o | output | 1 | Transmit word-start strobe |
| tx_underrun_o | output | 1 | Current word is a zero fill |
| rx_lane_i | input | 4 | Receive data lines |
| rx_aux_i | input | 1 | Receive side line |
| rx_strobe_i | input | 1 | Receive word-start strobe |
| rx_word_o | output | 16 | Assembled word |
| rx_aux_word_o | output | 4 | Assembled side word |
| rx_valid_o | output | 1 | One-cycle pulse for a complete word |
| rx_frame_err_o | output | 1 | One-cycle framing fault pulse |

## Verification
A word accepted while `tx_ready_o` is high shows its slot-0 nibble one cycle later and its slot-3 nibble four cycles later. In loopback, that word appears on `rx_valid_o` one cycle after its slot 3, which is the slot-0 cycle of the following word. Framing faults show one cycle after the strobe cycle at fault. All inputs change and all outputs are sampled on the falling edge, so each check reads the state left by exactly the rising edges counted above.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_LANES  = 4;

  function automatic int unsigned slot_bits(input int unsigned slots);
    return (slots < 2) ? 1 : $clog2(slots);
  endfunction
endpackage

// File: rtl/nl_slot_ctr.sv
module nl_slot_ctr #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned RST_SLOT = 0,
  localparam int unsigned SW      = nl_pkg::slot_bits(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic [SW-1:0] slot_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  // sync_i marks the current cycle as slot 0, so the next is slot 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= SW'(RST_SLOT);
    else if (sync_i)         slot_q <= SW'(1);
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + SW'(1);
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/nl_tx_ser.sv
module nl_tx_ser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned SLOTS = WORD_W / LANES,
  localparam int unsigned SW    = nl_pkg::slot_bits(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     slot_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOTS-1:0]  aux_word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [LANES-1:0]  lane_o,
  output logic              aux_o,
  output logic              strobe_o,
  output logic              underrun_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [WORD_W-1:0] hold_q;
  logic [SLOTS-1:0]  aux_q;
  logic              und_q;

  assign ready_o = (slot_i == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      aux_q  <= '0;
      und_q  <= 1'b0;
    end else if (ready_o) begin
      hold_q <= valid_i ? word_i : '0;
      aux_q  <= valid_i ? aux_word_i : '0;
      und_q  <= !valid_i;
    end
  end

  assign lane_o     = hold_q[slot_i*LANES +: LANES];
  assign aux_o      = aux_q[slot_i];
  assign strobe_o   = (slot_i == '0);
  assign underrun_o = und_q;
endmodule

// File: rtl/nl_rx_deser.sv
module nl_rx_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned SLOTS = WORD_W / LANES,
  localparam int unsigned SW    = nl_pkg::slot_bits(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     slot_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic              aux_i,
  input  logic              strobe_i,
  output logic [WORD_W-1:0] word_o,
  output logic [SLOTS-1:0]  aux_word_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic              lock_q;
  logic [WORD_W-1:0] asm_q, asm_d;
  logic [SLOTS-1:0]  aux_asm_q, aux_asm_d;
  logic [SW-1:0]     pos;
  logic              capture, finish, fault;

  always_comb begin
    pos       = strobe_i ? '0 : slot_i;
    capture   = strobe_i || (lock_q && slot_i != '0);
    finish    = capture && (pos == LAST);
    // early strobe, or strobe absent where slot 0 was due
    fault     = lock_q && (strobe_i ? (slot_i != '0) : (slot_i == '0));
    asm_d     = asm_q;
    aux_asm_d = aux_asm_q;
    asm_d[pos*LANES +: LANES] = lane_i;
    aux_asm_d[pos]            = aux_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      asm_q       <= '0;
      aux_asm_q   <= '0;
      word_o      <= '0;
      aux_word_o  <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= finish;
      frame_err_o <= fault;
      if (strobe_i)            lock_q <= 1'b1;
      else if (slot_i == '0)   lock_q <= 1'b0;
      if (capture) begin
        asm_q     <= asm_d;
        aux_asm_q <= aux_asm_d;
      end
      if (finish) begin
        word_o     <= asm_d;
        aux_word_o <= aux_asm_d;
      end
    end
  end
endmodule

// File: rtl/nibble_link.sv
module nibble_link #(
  parameter int unsigned WORD_W = nl_pkg::DEF_WORD_W,
  parameter int unsigned LANES  = nl_pkg::DEF_LANES,
  localparam int unsigned SLOTS = WORD_W / LANES,
  localparam int unsigned SW    = nl_pkg::slot_bits(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [SLOTS-1:0]  tx_aux_word_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [LANES-1:0]  tx_lane_o,
  output logic              tx_aux_o,
  output logic              tx_strobe_o,
  output logic              tx_underrun_o,
  input  logic [LANES-1:0]  rx_lane_i,
  input  logic              rx_aux_i,
  input  logic              rx_strobe_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic [SLOTS-1:0]  rx_aux_word_o,
  output logic              rx_valid_o,
  output logic              rx_frame_err_o
);
  logic [SW-1:0] tx_slot, rx_slot;

  // transmit slot starts at the load slot so reset leaves the strobe low
  nl_slot_ctr #(.SLOTS(SLOTS), .RST_SLOT(SLOTS - 1)) u_tx_ctr (
    .clk_i, .rst_ni, .sync_i(1'b0), .slot_o(tx_slot)
  );

  nl_slot_ctr #(.SLOTS(SLOTS), .RST_SLOT(0)) u_rx_ctr (
    .clk_i, .rst_ni, .sync_i(rx_strobe_i), .slot_o(rx_slot)
  );

  nl_tx_ser #(.WORD_W(WORD_W), .LANES(LANES)) u_tx (
    .clk_i, .rst_ni,
    .slot_i(tx_slot), .word_i(tx_word_i), .aux_word_i(tx_aux_word_i),
    .valid_i(tx_valid_i), .ready_o(tx_ready_o), .lane_o(tx_lane_o),
    .aux_o(tx_aux_o), .strobe_o(tx_strobe_o), .underrun_o(tx_underrun_o)
  );

  nl_rx_deser #(.WORD_W(WORD_W), .LANES(LANES)) u_rx (
    .clk_i, .rst_ni,
    .slot_i(rx_slot), .lane_i(rx_lane_i), .aux_i(rx_aux_i),
    .strobe_i(rx_strobe_i), .word_o(rx_word_o), .aux_word_o(rx_aux_word_o),
    .valid_o(rx_valid_o), .frame_err_o(rx_frame_err_o)
  );
endmodule

// File: rtl/nibble_link_chk.sv
module nibble_link_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned SLOTS = WORD_W / LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] tx_word_i,
  input logic [SLOTS-1:0]  tx_aux_word_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic [LANES-1:0]  tx_lane_o,
  input logic              tx_aux_o,
  input logic              tx_strobe_o,
  input logic              tx_underrun_o,
  input logic              rx_valid_o,
  input logic              rx_frame_err_o
);
  AST_TX_FIRST_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && tx_valid_i) |=> (tx_lane_o == $past(tx_word_i[LANES-1:0]))); // R1

  AST_TX_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |=> !tx_strobe_o); // R2

  AST_TX_FIRST_AUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && tx_valid_i) |=> (tx_aux_o == $past(tx_aux_word_i[0]))); // R3

  AST_TX_LOAD_THEN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> tx_strobe_o); // R4

  AST_TX_UNDERRUN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> (tx_underrun_o && tx_lane_o == '0 && !tx_aux_o)); // R5

  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6

  AST_RX_ERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_err_o |-> !rx_valid_o); // R7

  AST_RX_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_err_o |=> !rx_frame_err_o); // R8
endmodule

bind nibble_link nibble_link_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .tx_word_i, .tx_aux_word_i, .tx_valid_i, .tx_ready_o,
  .tx_lane_o, .tx_aux_o, .tx_strobe_o, .tx_underrun_o, .rx_valid_o, .rx_frame_err_o
);

// File: tb/nibble_link_bench.sv
module nibble_link_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_word = '0;
  logic [3:0]  tx_aux_word = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_aux, tx_strobe, tx_underrun;
  logic [3:0]  tx_lane;
  logic        loop = 1'b0;
  logic [3:0]  man_lane = '0;
  logic        man_aux = 1'b0, man_strobe = 1'b0;
  logic [3:0]  rx_lane;
  logic        rx_aux, rx_strobe;
  logic [15:0] rx_word;
  logic [3:0]  rx_aux_word;
  logic        rx_valid, rx_frame_err;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign rx_lane   = loop ? tx_lane   : man_lane;
  assign rx_aux    = loop ? tx_aux    : man_aux;
  assign rx_strobe = loop ? tx_strobe : man_strobe;

  nibble_link u_nibble_link (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_word_i(tx_word), .tx_aux_word_i(tx_aux_word), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_lane_o(tx_lane), .tx_aux_o(tx_aux),
    .tx_strobe_o(tx_strobe), .tx_underrun_o(tx_underrun),
    .rx_lane_i(rx_lane), .rx_aux_i(rx_aux), .rx_strobe_i(rx_strobe),
    .rx_word_o(rx_word), .rx_aux_word_o(rx_aux_word),
    .rx_valid_o(rx_valid), .rx_frame_err_o(rx_frame_err)
  );

  function automatic logic [3:0] nib(input logic [15:0] w, input int k);
    return w[4*k +: 4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // transmit one word in loopback; checks the previous word on the receive side
  logic [15:0] prev_w = '0;
  logic [3:0]  prev_a = '0;
  bit          have_prev = 1'b0;

  task automatic send(input logic [15:0] w, input logic [3:0] a, input logic v);
    logic [15:0] ew;
    logic [3:0]  ea;
    while (!tx_ready) @(negedge clk);
    check("R4 ready in load slot", tx_ready, 1'b1);
    tx_word = w; tx_aux_word = a; tx_valid = v;
    ew = v ? w : 16'h0;
    ea = v ? a : 4'h0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) tx_valid = 1'b0;
      check("R1 lane nibble", tx_lane, nib(ew, k));
      check("R3 aux bit", tx_aux, ea[k]);
      check("R2 strobe", tx_strobe, k == 0);
      check("R5 underrun flag", tx_underrun, !v);
      check("R7 no frame error in loopback", rx_frame_err, 1'b0);
      check("R6 valid timing", rx_valid, (k == 0) && have_prev);
      if (k == 0 && have_prev) begin
        check("R6 word", rx_word, prev_w);
        check("R6 aux word", rx_aux_word, prev_a);
      end
    end
    prev_w = ew; prev_a = ea; have_prev = 1'b1;
  endtask

  task automatic rx_step(input logic [3:0] l, input logic x, input logic s);
    man_lane = l; man_aux = x; man_strobe = s;
    @(negedge clk);
  endtask

  task automatic rx_full(input logic [15:0] w, input logic [3:0] a, input string req);
    for (int k = 0; k < 4; k++) begin
      rx_step(nib(w, k), a[k], k == 0);
      check({req, " valid"}, rx_valid, k == 3);
      check({req, " no error"}, rx_frame_err, 1'b0);
    end
    check({req, " word"}, rx_word, w);
    check({req, " aux word"}, rx_aux_word, a);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [3:0]  a;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 tx_lane in reset", tx_lane, 4'h0);
    check("R10 tx_aux in reset", tx_aux, 1'b0);
    check("R10 strobe in reset", tx_strobe, 1'b0);
    check("R10 underrun in reset", tx_underrun, 1'b0);
    check("R10 ready in reset", tx_ready, 1'b1);
    check("R10 rx_valid in reset", rx_valid, 1'b0);
    check("R10 frame_err in reset", rx_frame_err, 1'b0);
    rst_n = 1'b1;

    // R9: idle lines before any strobe
    for (int i = 0; i < 6; i++) begin
      rx_step(4'($urandom), 1'($urandom), 1'b0);
      check("R9 no valid before lock", rx_valid, 1'b0);
      check("R9 no error before lock", rx_frame_err, 1'b0);
    end

    // R6: clean words back to back
    rx_full(16'hA5C3, 4'b1010, "R6");
    rx_full(16'h0F1E, 4'b0110, "R6");

    // R7: early strobe after two slots
    rx_step(4'h7, 1'b1, 1'b1);
    rx_step(4'h8, 1'b0, 1'b0);
    w = 16'hBEEF; a = 4'b1101;
    rx_step(nib(w, 0), a[0], 1'b1);
    check("R7 frame error on early strobe", rx_frame_err, 1'b1);
    check("R7 partial discarded", rx_valid, 1'b0);
    for (int k = 1; k < 4; k++) begin
      rx_step(nib(w, k), a[k], 1'b0);
      check("R7 error is one pulse", rx_frame_err, 1'b0);
      check("R7 valid after realign", rx_valid, k == 3);
    end
    check("R7 realigned word", rx_word, w);
    check("R7 realigned aux", rx_aux_word, a);

    // R8: strobe missing where slot 0 is due
    rx_step(4'h3, 1'b1, 1'b0);
    check("R8 frame error on missing strobe", rx_frame_err, 1'b1);
    check("R8 no valid", rx_valid, 1'b0);
    for (int i = 0; i < 5; i++) begin
      rx_step(4'($urandom), 1'($urandom), 1'b0);
      check("R8 unlocked no valid", rx_valid, 1'b0);
      check("R8 unlocked no error", rx_frame_err, 1'b0);
    end
    rx_full(16'h1234, 4'b0011, "R8 relock");

    // loopback phase
    rst_n = 1'b0;
    @(negedge clk);
    loop = 1'b1;
    rst_n = 1'b1;
    send(16'h8421, 4'b1001, 1'b1);
    send(16'hFFFF, 4'b1111, 1'b1);
    send(16'h0000, 4'b0000, 1'b0);   // R5 underrun
    send(16'h0001, 4'b0001, 1'b1);
    send(16'h8000, 4'b1000, 1'b1);
    for (int i = 0; i < 60; i++)
      send(16'($urandom), 4'($urandom), ($urandom % 5) != 0);
    @(negedge clk);
    check("R6 last word valid", rx_valid, 1'b1);
    check("R6 last word", rx_word, prev_w);
    check("R6 last aux", rx_aux_word, prev_a);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule